// File: doc/BRIEF.md
# Pin Bank Direction and Output Register Block

This block is the register front end of a 32-pin general-purpose I/O bank. It sits on a plain 32-bit memory-mapped bus that carries a write strobe, an address and write data, and returns read data combinationally. Each pin has a direction bit and an output latch bit. The direction bit drives the pad output-enable. The latch bit drives the pad's output value. The pad input levels pass through a synchroniser so that software can read them safely.

The direction bits are never written as a whole word. One address sets the bits whose write-data bit is 1, and a second address clears them. Pins written with a 0 keep their state, so two agents can change different pins without a read-modify-write. The output latch is written one half-word at a time. Each half register uses its upper 16 write bits as a per-bit enable for its lower 16 bits. A single pin can therefore be changed by one write, without disturbing the other pins. The latch accepts writes whatever the pin's direction, so a level can be placed on a pin before it starts to drive.

Top module: `pin_bank_regs`

## Requirements
- R1: A write to byte offset 0x00 sets to 1 (output) the direction bit of every pin whose write-data bit is 1. Pins whose write-data bit is 0 keep their direction.
- R2: A write to byte offset 0x04 clears to 0 (input) the direction bit of every pin whose write-data bit is 1. Pins whose write-data bit is 0 keep their direction.
- R3: A write to offset 0x08 updates latch bits 0..15, and a write to offset 0x0C updates latch bits 16..31. In both, write bit n is the new value of bit n of that half and write bit 16+n is its enable.
- R4: A latch bit whose enable bit (write bit 16+n) is 0 keeps its previous value, whatever write bit n holds.
- R5: Latch writes take effect while a pin is an input. A preloaded value appears on the pad as soon as the pin becomes an output, and the latch itself does not change.
- R6: A read at offset 0x10 returns the pad input levels through a two-stage synchroniser. A pad change made just after a clock edge shows in the read after the second rising edge, and not after the first.
- R7: After reset every direction bit is 0 (all pins inputs) and every latch bit is 0.
- R8: Reads at 0x00 and 0x04 return the direction state. Reads at 0x08 and 0x0C return latch bits 0..15 and 16..31 in the low half, with zeros in bits 31..16.
- R9: pad_oe[n] equals pin n's direction bit and pad_out[n] equals latch bit n at all times.
- R10: Writes to any other offset (for example 0x10 or 0x14) change neither direction nor latch, and reads at unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_oe | output | 32 | Per-pin output enable |
| pad_out | output | 32 | Per-pin driven value |

## Verification
The bench sends set and clear writes that overlap pins already in the target state. A design that overwrote the whole direction word, instead of merging it, would then lose pins it had no business touching. Half-word writes with partial masks, including an all-zero mask carrying all-ones data, catch a latch that ignores its enable bits or applies the mask to the wrong half. A value preloaded into an input pin, which later becomes an output, catches a latch that is gated by direction. The synchroniser is read after one edge and after two, which exposes a missing stage or an extra one. Writes to unmapped offsets expose a decode that aliases them onto real registers.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;
   // Byte offsets; software and neighbours decode these, so they are fixed.
   localparam int OFS_DIR_SET = 'h00;
   localparam int OFS_DIR_CLR = 'h04;
   localparam int OFS_OUT_LO  = 'h08;
   localparam int OFS_PIN_LVL = 'h10;
   localparam int OFS_STRIDE  = 4;

   // Offset of the output half register h.
   function automatic int out_half_ofs(input int h);
      return OFS_OUT_LO + OFS_STRIDE * h;
   endfunction
endpackage

// File: rtl/pin_dir_ctrl.sv
module pin_dir_ctrl #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic             clr_en,
   input  logic [WIDTH-1:0] bits,
   output logic [WIDTH-1:0] dir
);
   logic [WIDTH-1:0] set_mask, clr_mask;

   assign set_mask = set_en ? bits : '0;
   assign clr_mask = clr_en ? bits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dir <= '0;
      else        dir <= (dir | set_mask) & ~clr_mask;
   end
endmodule

// File: rtl/pin_out_latch.sv
module pin_out_latch #(
   parameter int HALF_W     = 16,
   parameter int NUM_HALVES = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_HALVES-1:0]          half_we,
   input  logic [2*HALF_W-1:0]            wdata,
   output logic [NUM_HALVES*HALF_W-1:0]   latch
);
   logic [HALF_W-1:0] wval, wen;

   assign wval = wdata[HALF_W-1:0];
   assign wen  = wdata[2*HALF_W-1:HALF_W];

   for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            latch[h*HALF_W +: HALF_W] <= '0;
         else if (half_we[h])
            latch[h*HALF_W +: HALF_W] <= (latch[h*HALF_W +: HALF_W] & ~wen)
                                         | (wval & wen);
      end
   end
endmodule

// File: rtl/pin_in_sync.sv
module pin_in_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   logic [WIDTH-1:0] stage [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage[i] <= '0;
      end else begin
         stage[0] <= async_in;
         for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
      end
   end

   assign sync_out = stage[STAGES-1];
endmodule

// File: rtl/pin_bank_regs.sv
module pin_bank_regs
   import pin_bank_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] pad_in,
   output logic [DATA_W-1:0] pad_oe,
   output logic [DATA_W-1:0] pad_out
);
   localparam int HALF_W     = DATA_W / 2;
   localparam int NUM_HALVES = DATA_W / HALF_W;

   if (DATA_W % 2 != 0) begin : g_bad_width
      $error("pin_bank_regs: DATA_W must be even");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pin_bank_regs: SYNC_STAGES must be at least 2");
   end
   if ((1 << ADDR_W) <= OFS_PIN_LVL) begin : g_bad_addr
      $error("pin_bank_regs: ADDR_W too narrow for the register map");
   end

   logic                  hit_set, hit_clr, hit_lvl;
   logic [NUM_HALVES-1:0] hit_half;
   logic [DATA_W-1:0]     dir_q, latch_q, lvl_q;

   assign hit_set = (bus_addr == ADDR_W'(OFS_DIR_SET));
   assign hit_clr = (bus_addr == ADDR_W'(OFS_DIR_CLR));
   assign hit_lvl = (bus_addr == ADDR_W'(OFS_PIN_LVL));

   for (genvar h = 0; h < NUM_HALVES; h++) begin : g_dec
      assign hit_half[h] = (bus_addr == ADDR_W'(out_half_ofs(h)));
   end

   pin_dir_ctrl #(.WIDTH(DATA_W)) u_dir (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (bus_wr && hit_set),
      .clr_en (bus_wr && hit_clr),
      .bits   (bus_wdata),
      .dir    (dir_q)
   );

   pin_out_latch #(.HALF_W(HALF_W), .NUM_HALVES(NUM_HALVES)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .half_we (bus_wr ? hit_half : '0),
      .wdata   (bus_wdata),
      .latch   (latch_q)
   );

   pin_in_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pad_in),
      .sync_out (lvl_q)
   );

   always_comb begin
      bus_rdata = '0;
      if (hit_set || hit_clr) bus_rdata = dir_q;
      if (hit_lvl)            bus_rdata = lvl_q;
      for (int h = 0; h < NUM_HALVES; h++) begin
         if (hit_half[h]) bus_rdata = {{(DATA_W-HALF_W){1'b0}}, latch_q[h*HALF_W +: HALF_W]};
      end
   end

   assign pad_oe  = dir_q;
   assign pad_out = latch_q;
endmodule

// File: rtl/pin_bank_regs_chk.sv
module pin_bank_regs_chk #(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [DATA_W-1:0] pad_in,
   input logic [DATA_W-1:0] pad_oe,
   input logic [DATA_W-1:0] pad_out
);
   localparam int H = DATA_W / 2;

   logic in_map;
   logic [1:0] since_rst;

   assign in_map = (bus_addr == ADDR_W'('h00)) || (bus_addr == ADDR_W'('h04)) ||
                   (bus_addr == ADDR_W'('h08)) || (bus_addr == ADDR_W'('h0C));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   p_dir_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'('h00)) |=> pad_oe == ($past(pad_oe) | $past(bus_wdata)));

   p_dir_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'('h04)) |=> pad_oe == ($past(pad_oe) & ~$past(bus_wdata)));

   p_out_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'('h08)) |=>
         pad_out[H-1:0] == (($past(pad_out[H-1:0]) & ~$past(bus_wdata[DATA_W-1:H]))
                          | ($past(bus_wdata[H-1:0]) & $past(bus_wdata[DATA_W-1:H])))
         && $stable(pad_out[DATA_W-1:H]));

   p_out_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'('h0C)) |=>
         pad_out[DATA_W-1:H] == (($past(pad_out[DATA_W-1:H]) & ~$past(bus_wdata[DATA_W-1:H]))
                               | ($past(bus_wdata[H-1:0]) & $past(bus_wdata[DATA_W-1:H])))
         && $stable(pad_out[H-1:0]));

   p_no_effect_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr || !in_map) |=> $stable(pad_oe) && $stable(pad_out));

   if (SYNC_STAGES == 2) begin : g_sync_chk
      p_sync_lvl_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (since_rst == 2'd3 && bus_addr == ADDR_W'('h10)) |-> bus_rdata == $past(pad_in, 2));
   end
endmodule

bind pin_bank_regs pin_bank_regs_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/tb_pin_bank_regs.sv
`timescale 1ns/1ps
module tb_pin_bank_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_oe, pad_out;

   int total = 0;
   int fails = 0;
   int cycles = 0;
   logic chk_req = 1'b0;

   // scoreboard: kind 0 = read data, 1 = pad_oe, 2 = pad_out
   int          q_kind[$];
   logic [31:0] q_exp[$];
   string       q_tag[$];

   always #2.5 clk = ~clk;

   pin_bank_regs dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_oe(pad_oe), .pad_out(pad_out)
   );

   // monitor: pops one expected item per request, at the falling edge
   always @(negedge clk) begin
      if (chk_req && q_kind.size() > 0) begin
         int          k;
         logic [31:0] e, a;
         string       t;
         k = q_kind.pop_front();
         e = q_exp.pop_front();
         t = q_tag.pop_front();
         a = (k == 0) ? bus_rdata : (k == 1) ? pad_oe : pad_out;
         total++;
         if (a !== e) begin
            fails++;
            $display("FAIL %s kind=%0d actual=%08h expected=%08h", t, k, a, e);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         fails++;
         total++;
         $display("FAIL watchdog actual=%0d expected<=100000", cycles);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   // both tasks are entered just after a rising edge and leave just after the next
   task automatic do_write(input logic [7:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic expect_val(input int kind, input logic [7:0] a,
                             input logic [31:0] e, input string tag);
      bus_addr = a;
      q_kind.push_back(kind); q_exp.push_back(e); q_tag.push_back(tag);
      chk_req = 1'b1;
      @(posedge clk); #1;
      chk_req = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      expect_val(1, 8'h00, 32'h0, "R7 oe after reset");
      expect_val(2, 8'h00, 32'h0, "R7 out after reset");
      expect_val(0, 8'h08, 32'h0, "R7 latch read after reset");

      do_write(8'h00, 32'h0000_00F5);
      expect_val(1, 8'h00, 32'h0000_00F5, "R1 set first pins");
      do_write(8'h00, 32'h8000_0100);
      expect_val(1, 8'h00, 32'h8000_01F5, "R1 zeros keep pins");
      do_write(8'h04, 32'h0000_0014);
      expect_val(1, 8'h00, 32'h8000_01E1, "R2 clear pins");
      expect_val(0, 8'h04, 32'h8000_01E1, "R8 dir read at 0x04");
      expect_val(0, 8'h00, 32'h8000_01E1, "R8 dir read at 0x00");

      do_write(8'h08, 32'hFFFF_A5C3);
      expect_val(2, 8'h00, 32'h0000_A5C3, "R3 low half full mask");
      do_write(8'h0C, 32'h00FF_1234);
      expect_val(2, 8'h00, 32'h0034_A5C3, "R3 high half partial mask");
      do_write(8'h08, 32'h0F00_0000);
      expect_val(2, 8'h00, 32'h0034_A0C3, "R4 masked clear of bits 11..8");
      do_write(8'h08, 32'h0000_FFFF);
      expect_val(2, 8'h00, 32'h0034_A0C3, "R4 zero mask keeps latch");
      expect_val(0, 8'h08, 32'h0000_A0C3, "R8 low half read");
      expect_val(0, 8'h0C, 32'h0000_0034, "R8 high half read");

      do_write(8'h0C, 32'h4000_4000);
      expect_val(2, 8'h00, 32'h4034_A0C3, "R5 preload on input pin");
      expect_val(1, 8'h00, 32'h8000_01E1, "R5 preload leaves direction");
      do_write(8'h00, 32'h4000_0000);
      expect_val(1, 8'h00, 32'hC000_01E1, "R9 oe follows direction");
      expect_val(2, 8'h00, 32'h4034_A0C3, "R9 out follows latch");

      do_write(8'h10, 32'hFFFF_FFFF);
      do_write(8'h14, 32'hFFFF_FFFF);
      expect_val(1, 8'h00, 32'hC000_01E1, "R10 stray write oe");
      expect_val(2, 8'h00, 32'h4034_A0C3, "R10 stray write out");
      expect_val(0, 8'h14, 32'h0, "R10 unmapped read");

      pad_in = 32'h1357_9BDF;
      expect_val(0, 8'h10, 32'h0, "R6 no change before first edge");
      expect_val(0, 8'h10, 32'h0, "R6 no change after one edge");
      expect_val(0, 8'h10, 32'h1357_9BDF, "R6 level after two edges");
      pad_in = 32'hFFFF_0000;
      expect_val(0, 8'h10, 32'h1357_9BDF, "R6 old level held");
      expect_val(0, 8'h10, 32'h1357_9BDF, "R6 old level one edge on");
      expect_val(0, 8'h10, 32'hFFFF_0000, "R6 second pattern");

      @(posedge clk); #1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule